// File: doc/BRIEF.md
# Bubble-Tolerant Circular Thermometer Decoder

This block turns a 32-bit circular thermometer word, frozen from the taps of a 64-phase ring oscillator when a timing event arrives, into a 6-bit fine phase code. In a time-to-digital converter it sits after each channel's capture register. Its code is joined to the coarse count to form a complete timestamp.

Each bit must agree with the two bits after it before a position counts as an edge. This means a single flipped bit can neither make an edge nor hide one. Positions run upward from bit 0 and wrap from bit 31 back to bit 0.

- **Falling edge:** a 1 followed by two 0s. When there is exactly one, the event is in the first half of the oscillator period. The code's top bit is 0 and the low five bits give the position.
- **Rising edge:** a 0 followed by two 1s. This search runs only when no falling edge exists. Exactly one match puts the event in the second half of the period. The top bit is then 1, with the position below it.
- **Fault:** any other outcome raises the error flag and forces the code to zero.

The result is held in a small result-class state machine with four states:

- `ST_IDLE`: nothing decoded since reset.
- `ST_LOW`: the last word had exactly one falling edge.
- `ST_HIGH`: the last word had no falling edge and exactly one rising edge.
- `ST_FAULT`: the last word matched neither case.

Every strobed word moves the machine from any state to `ST_LOW`, `ST_HIGH` or `ST_FAULT`. Without a strobe the machine stays where it is, and the outputs keep the last result. The valid output is the strobe delayed by one clock.

Top module: `tdec_top`

## Requirements
- R1: Out of reset, fine_valid, fine_err and fine_code are all 0.
- R2: Suppose a strobed word has exactly one index i where bit i is 1 and bits (i+1) mod 32 and (i+2) mod 32 are both 0. Then the next cycle shows fine_code = i with bit 5 (the MSB) at 0, and fine_err = 0.
- R3: Index arithmetic wraps modulo 32. A falling edge at bit 30 or 31 uses bits 0 and 1 as its following bits, and its code is 30 or 31.
- R4: An isolated 0 inside a run of ones, with 1s on both sides, is not a falling edge. The code is taken from the true edge alone.
- R5: Suppose a strobed word has no falling-edge match and exactly one index i where bit i is 0 and bits (i+1) mod 32 and (i+2) mod 32 are 1. Then fine_code = 32 + i and fine_err = 0.
- R6: Two or more falling-edge matches give fine_err = 1 and fine_code = 0. There is no fallback to the rising search.
- R7: A word with no falling-edge match gives fine_err = 1 and fine_code = 0 if it also has either no rising-edge match or more than one. Examples are all zeros, all ones and alternating bits.
- R8: fine_valid equals raw_valid delayed by one clock. While raw_valid is low, fine_code and fine_err keep their last values whatever raw_word does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| raw_word | input | 32 | Captured circular thermometer word |
| raw_valid | input | 1 | Strobe marking raw_word as a new sample |
| fine_code | output | 6 | Fine phase code: MSB is the half-period, low 5 bits are the position |
| fine_valid | output | 1 | Strobe delayed by one clock |
| fine_err | output | 1 | No usable edge, or an ambiguous one |

## Verification
The bench targets the following corner cases:

- **Edges at bits 30 and 31.** A decoder that does not wrap modulo 32 would miss these edges or report a fault.
- **A lone zero inside a run of ones.** A two-bit edge test would report that zero as the edge.
- **Words that only the rising search can resolve, including a zero at bit 31.** A design that skipped this search, or set the MSB wrongly, would report a fault or a first-half code.
- **A stray 1 and two separate runs.** A design that fell through to the rising search, or kept the lowest match, would return a plausible but wrong code instead of the error.
- **Idle cycles carrying garbage words.** These show whether the outputs hold while the strobe is low.

// File: rtl/tdec_pkg.sv
package tdec_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2,
        ST_FAULT = 2'd3
    } tdec_state_t;
endpackage

// File: rtl/tdec_pattern_scan.sv
// Marks every circular position whose bit equals LEAD while the next two
// bits (modulo N) hold the opposite value.
module tdec_pattern_scan #(
    parameter int N    = 32,
    parameter bit LEAD = 1'b1
) (
    input  logic [N-1:0] word,
    output logic [N-1:0] hits
);
    for (genvar g = 0; g < N; g++) begin : g_pos
        localparam int NEXT1 = (g + 1) % N;
        localparam int NEXT2 = (g + 2) % N;
        assign hits[g] = (word[g] == LEAD) && (word[NEXT1] != LEAD) && (word[NEXT2] != LEAD);
    end
endmodule

// File: rtl/tdec_hit_encode.sv
// Lowest set position of a hit vector, plus none / more-than-one flags.
module tdec_hit_encode #(
    parameter int N     = 32,
    localparam int IW   = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic [IW-1:0] idx,
    output logic          none,
    output logic          multi
);
    int cnt;

    always_comb begin
        idx = '0;
        cnt = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                idx = IW'(i);
            end
            cnt = cnt + int'(hits[i]);
        end
        none  = (cnt == 0);
        multi = (cnt > 1);
    end
endmodule

// File: rtl/tdec_top.sv
module tdec_top
    import tdec_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] raw_word,
    input  logic              raw_valid,
    output logic [IDX_W:0]    fine_code,
    output logic              fine_valid,
    output logic              fine_err
);
    logic [WORD_W-1:0] fall_hits, rise_hits;
    logic [IDX_W-1:0]  fall_idx, rise_idx;
    logic              fall_none, fall_multi, rise_none, rise_multi;
    logic              fall_single, rise_single;

    tdec_pattern_scan #(.N(WORD_W), .LEAD(1'b1)) u_fall_scan (
        .word(raw_word), .hits(fall_hits)
    );
    tdec_pattern_scan #(.N(WORD_W), .LEAD(1'b0)) u_rise_scan (
        .word(raw_word), .hits(rise_hits)
    );
    tdec_hit_encode #(.N(WORD_W)) u_fall_enc (
        .hits(fall_hits), .idx(fall_idx), .none(fall_none), .multi(fall_multi)
    );
    tdec_hit_encode #(.N(WORD_W)) u_rise_enc (
        .hits(rise_hits), .idx(rise_idx), .none(rise_none), .multi(rise_multi)
    );

    assign fall_single = !fall_none && !fall_multi;
    assign rise_single = fall_none && !rise_none && !rise_multi;

    tdec_state_t       state_q, state_d;
    logic [IDX_W-1:0]  pos_q, pos_d;
    logic              vld_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        if (raw_valid) begin
            if (fall_single) begin
                state_d = ST_LOW;
                pos_d   = fall_idx;
            end else if (rise_single) begin
                state_d = ST_HIGH;
                pos_d   = rise_idx;
            end else begin
                state_d = ST_FAULT;
                pos_d   = '0;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pos_q   <= '0;
            vld_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            vld_q   <= raw_valid;
        end
    end

    // outputs
    always_comb begin
        fine_valid = vld_q;
        unique case (state_q)
            ST_IDLE: begin
                fine_code = '0;
                fine_err  = 1'b0;
            end
            ST_LOW: begin
                fine_code = {1'b0, pos_q};
                fine_err  = 1'b0;
            end
            ST_HIGH: begin
                fine_code = {1'b1, pos_q};
                fine_err  = 1'b0;
            end
            ST_FAULT: begin
                fine_code = '0;
                fine_err  = 1'b1;
            end
        endcase
    end

    p_valid_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        raw_valid |=> fine_valid);
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> !fine_valid);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !raw_valid |=> ($stable(fine_code) && $stable(fine_err)));
    p_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fine_err |-> (fine_code == '0));
    p_flat_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_valid && (raw_word == '0 || raw_word == '1)) |=> fine_err);
endmodule

// File: tb/sim_tdec_top.sv
`timescale 1ns/1ps
module sim_tdec_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] raw_word = '0;
    logic        raw_valid = 1'b0;
    logic [5:0]  fine_code;
    logic        fine_valid;
    logic        fine_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_tag = "R1";

    logic [5:0] exp_code = '0;
    logic       exp_valid = 1'b0;
    logic       exp_err = 1'b0;
    string      exp_tag = "R1";

    always #2.5 clk = ~clk;

    tdec_top u0 (
        .clk(clk), .rst_n(rst_n), .raw_word(raw_word), .raw_valid(raw_valid),
        .fine_code(fine_code), .fine_valid(fine_valid), .fine_err(fine_err)
    );

    function automatic void ref_decode(input logic [31:0] w, output logic [5:0] c, output logic e);
        int nf, nr, pf, pr;
        nf = 0; nr = 0; pf = 0; pr = 0;
        for (int i = 0; i < 32; i++) begin
            if (w[i] && !w[(i+1)%32] && !w[(i+2)%32]) begin
                if (nf == 0) pf = i;
                nf++;
            end
            if (!w[i] && w[(i+1)%32] && w[(i+2)%32]) begin
                if (nr == 0) pr = i;
                nr++;
            end
        end
        if (nf == 1) begin
            c = 6'(pf); e = 1'b0;
        end else if (nf == 0 && nr == 1) begin
            c = 6'(32 + pr); e = 1'b0;
        end else begin
            c = 6'd0; e = 1'b1;
        end
    endfunction

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            exp_code = '0; exp_err = 1'b0; exp_valid = 1'b0;
        end else begin
            exp_valid = raw_valid;
            if (raw_valid) ref_decode(raw_word, exp_code, exp_err);
        end
        exp_tag = cur_tag;
    end

    // comparison on every falling edge
    always @(negedge clk) begin
        if (cycles > 0) begin
            checks++;
            if (fine_valid !== exp_valid || fine_code !== exp_code || fine_err !== exp_err) begin
                errors++;
                $display("FAIL %s: got valid=%0b code=%0d err=%0b, expected valid=%0b code=%0d err=%0b",
                         exp_tag, fine_valid, fine_code, fine_err, exp_valid, exp_code, exp_err);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: got no end, expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic drive(input logic [31:0] w, input logic v, input string tag);
        @(negedge clk);
        raw_word  = w;
        raw_valid = v;
        cur_tag   = tag;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        checks++;
        if (fine_valid !== 1'b0 || fine_code !== 6'd0 || fine_err !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%0b code=%0d err=%0b, expected 0 0 0", fine_valid, fine_code, fine_err);
        end
        rst_n = 1'b1;
        // R2: plain runs from bit 0 to bit k
        for (int k = 2; k < 30; k += 3) drive((32'd1 << (k + 1)) - 32'd1, 1'b1, "R2");
        drive(32'h0000_0FF0, 1'b1, "R2");
        // R3: wrap-around edges
        drive(32'h7FF0_0000, 1'b1, "R3");
        drive(32'hFE00_0000, 1'b1, "R3");
        drive(32'hF000_000F, 1'b1, "R3");
        drive(32'h8000_0000, 1'b1, "R3");
        // R4: isolated zero inside the run
        drive(32'h0000_FF7F, 1'b1, "R4");
        drive(32'h0000_FFFE & 32'h0000_FFFB, 1'b1, "R4");
        // R5: rising search only
        drive(~(32'd1 << 9), 1'b1, "R5");
        drive(32'h7FFF_FFFF, 1'b1, "R5");
        drive(32'hBFFF_FFFF, 1'b1, "R5");
        drive(~32'd1, 1'b1, "R5");
        // R6: ambiguous falling edges
        drive(32'h0000_3C0F, 1'b1, "R6");
        drive(32'h0100_FFFF, 1'b1, "R6");
        // R7: no usable edge
        drive(32'h0000_0000, 1'b1, "R7");
        drive(32'hFFFF_FFFF, 1'b1, "R7");
        drive(32'h5555_5555, 1'b1, "R7");
        drive(32'hAAAA_AAAA, 1'b1, "R7");
        drive(~((32'd1 << 4) | (32'd1 << 20)), 1'b1, "R7");
        // R8: idle cycles with garbage, then resume
        drive(32'h0000_00FF, 1'b1, "R8");
        drive(32'hFFFF_FFFF, 1'b0, "R8");
        drive(32'h1234_5678, 1'b0, "R8");
        drive(32'h7FFF_FFFF, 1'b0, "R8");
        drive(32'h0003_FFFF, 1'b1, "R8");
        drive(32'h0000_0000, 1'b0, "R8");
        drive(32'h0000_0000, 1'b0, "R8");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule